// File: doc/BRIEF.md
# Boundary-Scan Test Port

This block is a serial test port for a memory device. It follows the usual sixteen-state controller, which is stepped by a test-mode select line sampled on each rising edge of the test clock. Four registers are built in. The instruction register chooses one data register. The data registers are a one-bit pass-through register, a 32-bit identification word, and a capture register that records a parallel word of pin levels. At any moment exactly one register sits between the serial input and the serial output.

Three functions are available: identification readout, bypass, and a sample operation. The sample operation only captures. It has no preload stage, so reaching the data-update state under it changes nothing, exactly as if the controller had paused. The port cannot drive pins, and it cannot reach the memory's address or data paths. The serial output changes only on falling clock edges. A separate enable reports when the output carries valid data; the output is meant to be high impedance at all other times.

Top module: `scan_tap`

## Requirements
- R1: While `rst_n` is low, the controller is held in Test-Logic-Reset, the identification instruction is selected, and `tdo_oe` is low. After release, a data scan with no instruction load returns the identification word.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. That state selects the identification instruction again.
- R3: `tms` and `tdi` are sampled on rising edges of `tck`. `tdo` and `tdo_oe` change only on falling edges.
- R4: In Capture-IR the instruction shift register loads a pattern whose two low bits are 01 and whose upper bits are 0. That pattern comes out on `tdo` LSB first, and the new code takes effect in Update-IR.
- R5: Code 3'b001 selects the identification register. It shifts out LSB first: bit 0 is 1, bits 11:1 hold the manufacturer code (default 11'h0A5), bits 17:12 hold the width code 100100, bits 23:18 hold the architecture code 001001, bits 28:24 hold the depth code 01011, and bits 31:29 hold the revision 000.
- R6: Code 3'b111 selects the bypass register. This is one bit, cleared in Capture-DR, so the first bit out is 0 and each later bit equals `tdi` from one cycle earlier.
- R7: Any code other than 3'b001 and 3'b010 behaves as bypass.
- R8: Code 3'b010 (sample) captures `pin_vals` in Capture-DR and shifts it out starting with `pin_vals[0]`.
- R9: Under the sample code, Update-DR has no effect. Data shifted in never reaches any output, and the next capture reports the pin levels present at that time.
- R10: `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR. Otherwise `tdo` is 0.
- R11: Pause-DR holds the selected shift register. Leaving through Exit2-DR back into Shift-DR continues the scan with no new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, steps the controller |
| tdi | input | 1 | Serial data in |
| pin_vals | input | NPINS | Pin levels captured by the sample instruction |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | High while `tdo` carries scan data |

## Verification
The identification word is read in three situations: just after reset, after a five-cycle `tms` escape from the middle of a scan, and during a slow scan that observes `tdo` on both clock edges. Together these separate reset selection from the escape path and from output timing. Bypass is driven with an alternating bit stream and with unassigned codes, so a missing clear or a missing one-cycle delay shows up. Sample scans use asymmetric pin words. The pins change after an Update-DR and during a pause, which tells a working capture apart from a preload or from a stray recapture.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;
  parameter int IR_W = 3;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_IDENT  = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] OP_SAMPLE = {{(IR_W-2){1'b0}}, 2'b10};
  localparam logic [IR_W-1:0] OP_BYPASS = '1;
  localparam logic [IR_W-1:0] IR_CAPT   = {{(IR_W-2){1'b0}}, 2'b01};
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st
);
  tap_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      TLR:    nxt = tms ? TLR    : RTI;
      RTI:    nxt = tms ? SEL_DR : RTI;
      SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR: nxt = tms ? EX1_DR : SH_DR;
      SH_DR:  nxt = tms ? EX1_DR : SH_DR;
      EX1_DR: nxt = tms ? UPD_DR : PA_DR;
      PA_DR:  nxt = tms ? EX2_DR : PA_DR;
      EX2_DR: nxt = tms ? UPD_DR : SH_DR;
      UPD_DR: nxt = tms ? SEL_DR : RTI;
      SEL_IR: nxt = tms ? TLR    : CAP_IR;
      CAP_IR: nxt = tms ? EX1_IR : SH_IR;
      SH_IR:  nxt = tms ? EX1_IR : SH_IR;
      EX1_IR: nxt = tms ? UPD_IR : PA_IR;
      PA_IR:  nxt = tms ? EX2_IR : PA_IR;
      EX2_IR: nxt = tms ? UPD_IR : SH_IR;
      UPD_IR: nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= TLR;
    else        st <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic [IR_W-1:0] ir,
  output logic            ir_lsb
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= IR_CAPT;
      ir    <= OP_IDENT;
    end else begin
      case (st)
        TLR:    ir    <= OP_IDENT;
        CAP_IR: ir_sh <= IR_CAPT;
        SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        UPD_IR: ir    <= ir_sh;
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          NPINS   = 16,
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = '1
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_e       st,
  input  logic [IR_W-1:0]  ir,
  input  logic [NPINS-1:0] pin_vals,
  output logic             dr_lsb,
  output logic             byp_q,
  output logic [NPINS-1:0] bsr_q
);
  logic            sel_id, sel_smp, sel_byp;
  logic [ID_W-1:0] id_sh;

  assign sel_id  = (ir == OP_IDENT);
  assign sel_smp = (ir == OP_SAMPLE);
  assign sel_byp = !sel_id && !sel_smp;

  // Identification register: capture-only, shifts toward bit 0
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                       id_sh <= ID_WORD;
    else if (sel_id && st == CAP_DR)  id_sh <= ID_WORD;
    else if (sel_id && st == SH_DR)   id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  // Sample register: capture and shift only; no update latch behind it
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                        bsr_q <= '0;
    else if (sel_smp && st == CAP_DR)  bsr_q <= pin_vals;
    else if (sel_smp && st == SH_DR)   bsr_q <= {tdi, bsr_q[NPINS-1:1]};
  end

  // Single-bit pass-through
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                        byp_q <= 1'b0;
    else if (sel_byp && st == CAP_DR)  byp_q <= 1'b0;
    else if (sel_byp && st == SH_DR)   byp_q <= tdi;
  end

  always_comb begin
    if (sel_id)       dr_lsb = id_sh[0];
    else if (sel_smp) dr_lsb = bsr_q[0];
    else              dr_lsb = byp_q;
  end
endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int         NPINS      = 16,
  parameter logic [2:0] REV_CODE   = 3'b000,
  parameter logic [4:0] DEPTH_CODE = 5'b01011,
  parameter logic [5:0] ARCH_CODE  = 6'b001001,
  parameter logic [5:0] WIDTH_CODE = 6'b100100,
  parameter logic [10:0] MFR_CODE  = 11'h0A5
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [NPINS-1:0] pin_vals,
  output logic             tdo,
  output logic             tdo_oe
);
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD =
    {REV_CODE, DEPTH_CODE, ARCH_CODE, WIDTH_CODE, MFR_CODE, 1'b1};

  tap_state_e       st;
  logic [IR_W-1:0]  ir;
  logic             ir_lsb, dr_lsb, byp_q;
  logic [NPINS-1:0] bsr_q;
  logic             oe_nxt, tdo_nxt;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .st(st));

  tap_ir u_ir (.tck(tck), .rst_n(rst_n), .tdi(tdi), .st(st), .ir(ir), .ir_lsb(ir_lsb));

  tap_dr #(.NPINS(NPINS), .ID_W(ID_W), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .st(st), .ir(ir),
    .pin_vals(pin_vals), .dr_lsb(dr_lsb), .byp_q(byp_q), .bsr_q(bsr_q)
  );

  assign oe_nxt  = (st == SH_IR) || (st == SH_DR);
  assign tdo_nxt = oe_nxt && ((st == SH_IR) ? ir_lsb : dr_lsb);

  // Output retimed to the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_oe <= oe_nxt;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic             tck,
  input logic             rst_n,
  input logic             tms,
  input logic [NPINS-1:0] pin_vals,
  input logic             tdo_oe,
  input tap_state_e       st,
  input logic [IR_W-1:0]  ir,
  input logic             byp_q,
  input logic [NPINS-1:0] bsr_q
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)           ones <= 3'd0;
    else if (!tms)        ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  p_tlr_ident_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (st == TLR) |=> (ir == OP_IDENT));

  p_escape_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones == 3'd5) |-> (st == TLR));

  p_byp_clear_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (st == CAP_DR && ir != OP_IDENT && ir != OP_SAMPLE) |=> (byp_q == 1'b0));

  p_smp_capt_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (st == CAP_DR && ir == OP_SAMPLE) |=> (bsr_q == $past(pin_vals)));

  p_upd_noop_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (st == UPD_DR) |=> $stable(bsr_q));

  p_oe_shift_r10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (st == SH_IR || st == SH_DR));

  p_pause_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (st == PA_DR) |=> ($stable(bsr_q) && $stable(byp_q)));
endmodule

bind scan_tap scan_tap_chk #(.NPINS(NPINS)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .pin_vals(pin_vals), .tdo_oe(tdo_oe),
  .st(st), .ir(ir), .byp_q(byp_q), .bsr_q(bsr_q)
);

// File: tb/scan_tap_test.sv
`timescale 1ns/1ps
module scan_tap_test;
  localparam int NP = 16;
  localparam logic [31:0] EXP_ID = {3'b000, 5'b01011, 6'b001001, 6'b100100, 11'h0A5, 1'b1};

  logic          tck = 1'b0;
  logic          rst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          tdo, tdo_oe;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  scan_tap #(.NPINS(NP)) uut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
    .pin_vals(pins), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always #4 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive, clock once, settle just after the falling edge
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic to_shift_dr();  // from Run-Test/Idle
    step(1, 0); step(0, 0); step(0, 0);
  endtask

  task automatic to_shift_ir();
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
  endtask

  task automatic finish_scan();  // Exit1 -> Update -> Idle
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] capt);
    logic [63:0] o;
    to_shift_ir();
    shift_bits(3, {61'd0, code}, o);
    finish_scan();
    capt = o[2:0];
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    to_shift_dr();
    shift_bits(n, din, dout);
    finish_scan();
  endtask

  task automatic t_reset();
    logic [63:0] o;
    chk(tdo_oe == 1'b0, "R1 oe low after reset", {63'd0, tdo_oe}, 64'd0);
    step(0, 0);
    to_shift_dr();
    chk(tdo_oe == 1'b1, "R10 oe in Shift-DR", {63'd0, tdo_oe}, 64'd1);
    shift_bits(32, 64'd0, o);
    chk(tdo_oe == 1'b0, "R10 oe low in Exit1-DR", {63'd0, tdo_oe}, 64'd0);
    finish_scan();
    chk(o[31:0] == EXP_ID, "R1 R5 ident after reset", o, {32'd0, EXP_ID});
  endtask

  task automatic t_ir_capture();
    logic [2:0] c;
    load_ir(3'b111, c);
    chk(c == 3'b001, "R4 capture pattern", {61'd0, c}, 64'd1);
  endtask

  task automatic t_bypass();
    logic [2:0]  c;
    logic [63:0] o;
    logic [63:0] din = 64'h0000_0000_0000_0155;
    load_ir(3'b111, c);
    scan_dr(9, din, o);
    chk(o[8:0] == {din[7:0], 1'b0}, "R6 bypass delay", {55'd0, o[8:0]}, {55'd0, din[7:0], 1'b0});
  endtask

  task automatic t_unknown();
    logic [2:0]  c;
    logic [63:0] o;
    logic [2:0]  codes [2] = '{3'b000, 3'b100};
    foreach (codes[k]) begin
      load_ir(codes[k], c);
      scan_dr(6, 64'h2D, o);
      chk(o[5:0] == 6'b011010, "R7 unknown acts as bypass", {58'd0, o[5:0]}, 64'b011010);
    end
  endtask

  task automatic t_sample();
    logic [2:0]  c;
    logic [63:0] o;
    pins = 16'hC3A5;
    load_ir(3'b010, c);
    scan_dr(NP, 64'h0, o);
    chk(o[NP-1:0] == 16'hC3A5, "R8 sample capture", o, 64'hC3A5);
  endtask

  task automatic t_sample_update();
    logic [63:0] o;
    pins = 16'h5A5A;
    scan_dr(NP, 64'h1234, o);
    chk(o[NP-1:0] == 16'h5A5A, "R8 sample second word", o, 64'h5A5A);
    chk(tdo == 1'b0 && tdo_oe == 1'b0, "R9 R10 quiet after update", {62'd0, tdo, tdo_oe}, 64'd0);
    pins = 16'h0F0F;
    scan_dr(NP, 64'h0, o);
    chk(o[NP-1:0] == 16'h0F0F, "R9 no preload seen", o, 64'h0F0F);
  endtask

  task automatic t_pause();
    logic [63:0] o = '0;
    pins = 16'hBEEF;
    to_shift_dr();
    for (int i = 0; i < 6; i++) begin
      o[i] = tdo;
      step(i == 5, 0);
    end
    step(0, 0);
    pins = 16'h0000;
    step(0, 0); step(0, 0);
    chk(tdo_oe == 1'b0, "R10 oe low in Pause-DR", {63'd0, tdo_oe}, 64'd0);
    step(1, 0);
    step(0, 0);
    for (int i = 6; i < NP; i++) begin
      o[i] = tdo;
      step(i == NP - 1, 0);
    end
    finish_scan();
    chk(o[NP-1:0] == 16'hBEEF, "R11 pause keeps scan", o, 64'hBEEF);
  endtask

  task automatic t_escape();
    logic [2:0]  c;
    logic [63:0] o;
    load_ir(3'b111, c);
    to_shift_dr();
    step(0, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk(tdo_oe == 1'b0, "R2 oe low after escape", {63'd0, tdo_oe}, 64'd0);
    step(0, 0);
    scan_dr(32, 64'd0, o);
    chk(o[31:0] == EXP_ID, "R2 ident after escape", o, {32'd0, EXP_ID});
  endtask

  task automatic t_edges();
    to_shift_dr();
    chk(tdo == EXP_ID[0], "R3 bit0", {63'd0, tdo}, {63'd0, EXP_ID[0]});
    step(0, 0);
    chk(tdo == EXP_ID[1], "R3 bit1", {63'd0, tdo}, {63'd0, EXP_ID[1]});
    tms = 1'b0;
    @(posedge tck);
    #1;
    chk(tdo == EXP_ID[1], "R3 held across rising edge", {63'd0, tdo}, {63'd0, EXP_ID[1]});
    @(negedge tck);
    #1;
    chk(tdo == EXP_ID[2], "R3 moves on falling edge", {63'd0, tdo}, {63'd0, EXP_ID[2]});
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    @(negedge tck);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_unknown();
    t_sample();
    t_sample_update();
    t_pause();
    t_escape();
    t_edges();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule